// File: doc/BRIEF.md
# Dual-Clock Two-Port Synchronous RAM

This block is a word-addressed memory with two fully independent access ports, left and right. Each port has its own clock and can read or write any word of the array while the other port does the same. Address, write data and control are taken on the rising edge of the port clock. A port does something only when both of its chip selects are true: one is active low and the other is active high. A write strobe, also active low, picks a write over a read.

Each port has its own static output-mode pin. With the pin low, the word at the captured address is presented during the cycle right after the edge. With the pin high, it is presented one cycle later from an output register. The output is modelled as a data bus plus a drive flag, which stands for the enabled state of a tri-state driver. An asynchronous active-low output enable gates that flag combinationally and changes no stored state.

When both ports write the same word on the same edge, the right port's data is kept. Depth is set by the address-width parameter and word size by the data-width parameter.

Top module: `dpr_ram`

## Requirements
- R1: A port is selected at a rising edge only when its active-low select is 0 and its active-high select is 1. An edge with either select inactive writes nothing, even when the write strobe is low.
- R2: At a selected edge, write strobe 0 stores the data input at the address input, and write strobe 1 starts a read of that address.
- R3: With the mode pin at 0 (flow-through), a read started at an edge drives the addressed word from that edge until the next edge. A write at the same edge by the other port to a different word does not disturb it.
- R4: With the mode pin at 1 (pipelined), a read started at an edge drives the word that address held before the following edge, and drives it from that following edge for one cycle.
- R5: An edge at which the port is not selected turns the drive flag off from that edge on, in both modes.
- R6: In pipelined mode, the drive flag turns on only after two consecutive selected edges, the first of which is a read.
- R7: Output enable high forces the drive flag to 0 at once, with no clock edge needed. Returning it to 0 restores the same word, because the output enable changes no internal state.
- R8: Whenever the drive flag is 0, the data output is all zeros.
- R9: The output after a write edge follows the controls of the previous edge. In flow-through mode it is off in the cycle after the write. In pipelined mode it shows the earlier read for one cycle and is off in the next.
- R10: Both ports work at the same time on different words. A word written by one port is read back unchanged by the other.
- R11: When both ports write the same word on the same edge, the word afterwards holds the right port's data.
- R12: While reset is low, and after it is released, both drive flags are 0 and both data outputs are 0 until a read is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset of the port control registers |
| l_clk | input | 1 | Left port clock |
| l_cs_n | input | 1 | Left select, active low |
| l_cs | input | 1 | Left select, active high |
| l_we_n | input | 1 | Left write strobe (0 write, 1 read) |
| l_oe_n | input | 1 | Left asynchronous output enable, active low |
| l_pipe | input | 1 | Left static mode pin (0 flow-through, 1 pipelined) |
| l_addr | input | AW | Left word address |
| l_din | input | DW | Left write data |
| l_dout | output | DW | Left read data, zero when not driven |
| l_drive | output | 1 | Left output drive flag |
| r_clk | input | 1 | Right port clock |
| r_cs_n | input | 1 | Right select, active low |
| r_cs | input | 1 | Right select, active high |
| r_we_n | input | 1 | Right write strobe (0 write, 1 read) |
| r_oe_n | input | 1 | Right asynchronous output enable, active low |
| r_pipe | input | 1 | Right static mode pin (0 flow-through, 1 pipelined) |
| r_addr | input | AW | Right word address |
| r_din | input | DW | Right write data |
| r_dout | output | DW | Right read data, zero when not driven |
| r_drive | output | 1 | Right output drive flag |

## Verification
Several drive-flag rules are checked on every clock of each port. These are: a deselected edge turns the output off, output enable high keeps it off, pipelined drive only after two selected edges, and the drive pattern after a write. Data values cannot be seen by those properties. Read latency in each mode, the word returned after writes from either port, a same-edge collision on one word, and the output coming back unchanged after an output-enable pulse between edges are shown only by the bench scenarios. There, a reference model predicts every output on every cycle.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

  // A port acts only with both selects in their true state.
  function automatic logic port_selected(input logic cs_n, input logic cs);
    return !cs_n && cs;
  endfunction

  // Left copy is newer when the two tracking flags differ.
  function automatic logic left_is_newer(input logic flag_l, input logic flag_r);
    return flag_l != flag_r;
  endfunction

endpackage

// File: rtl/dpr_store.sv
module dpr_store #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          a_clk,
  input  logic          a_we,
  input  logic [AW-1:0] a_waddr,
  input  logic [DW-1:0] a_wdata,
  input  logic [AW-1:0] a_raddr,
  output logic [DW-1:0] a_rdata,
  input  logic          b_clk,
  input  logic          b_we,
  input  logic [AW-1:0] b_waddr,
  input  logic [DW-1:0] b_wdata,
  input  logic [AW-1:0] b_raddr,
  output logic [DW-1:0] b_rdata
);
  import dpr_pkg::*;
  localparam int DEPTH = 1 << AW;

  // One data copy per writing port; a flag pair per word tells which copy is newer.
  logic [DW-1:0] mem_a [DEPTH];
  logic [DW-1:0] mem_b [DEPTH];
  logic          flg_a [DEPTH];
  logic          flg_b [DEPTH];

  // Same-word write on the same edge: port b (right) wins.
  logic a_we_eff;
  assign a_we_eff = a_we && !(b_we && (b_waddr == a_waddr));

  always_ff @(posedge a_clk) begin
    if (a_we_eff) begin
      mem_a[a_waddr] <= a_wdata;
      flg_a[a_waddr] <= !flg_b[a_waddr];
    end
  end

  always_ff @(posedge b_clk) begin
    if (b_we) begin
      mem_b[b_waddr] <= b_wdata;
      flg_b[b_waddr] <= flg_a[b_waddr];
    end
  end

  assign a_rdata = left_is_newer(flg_a[a_raddr], flg_b[a_raddr]) ? mem_a[a_raddr] : mem_b[a_raddr];
  assign b_rdata = left_is_newer(flg_a[b_raddr], flg_b[b_raddr]) ? mem_a[b_raddr] : mem_b[b_raddr];

endmodule

// File: rtl/dpr_port.sv
module dpr_port #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          cs,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic          pipe,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic          sel,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data,
  output logic [DW-1:0] dout,
  output logic          drive
);
  import dpr_pkg::*;

  logic          rd_q;     // a read was started at the last edge
  logic          pdrv_q;   // pipelined drive: read one edge back and selected now
  logic [AW-1:0] addr_q;
  logic [DW-1:0] pdat_q;
  logic          drv_int;
  logic [DW-1:0] dat_int;

  assign sel     = port_selected(cs_n, cs);
  assign wr_en   = sel && !we_n;
  assign wr_addr = addr;
  assign wr_data = din;
  assign rd_addr = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= 1'b0;
      pdrv_q <= 1'b0;
      addr_q <= '0;
      pdat_q <= '0;
    end else begin
      rd_q   <= sel && we_n;
      pdrv_q <= rd_q && sel;
      addr_q <= addr;
      if (rd_q) pdat_q <= rd_data;
    end
  end

  assign drv_int = pipe ? pdrv_q : rd_q;
  assign dat_int = pipe ? pdat_q : rd_data;
  assign drive   = drv_int && !oe_n;
  assign dout    = drive ? dat_int : '0;

endmodule

// File: rtl/dpr_ram.sv
module dpr_ram #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          rst_n,
  input  logic          l_clk,
  input  logic          l_cs_n,
  input  logic          l_cs,
  input  logic          l_we_n,
  input  logic          l_oe_n,
  input  logic          l_pipe,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_din,
  output logic [DW-1:0] l_dout,
  output logic          l_drive,
  input  logic          r_clk,
  input  logic          r_cs_n,
  input  logic          r_cs,
  input  logic          r_we_n,
  input  logic          r_oe_n,
  input  logic          r_pipe,
  input  logic [AW-1:0] r_addr,
  input  logic [DW-1:0] r_din,
  output logic [DW-1:0] r_dout,
  output logic          r_drive
);
  // Named internal events for the checker.
  logic          l_sel, r_sel, l_wr, r_wr;
  logic [AW-1:0] l_wa, r_wa, l_ra, r_ra;
  logic [DW-1:0] l_wd, r_wd, l_rd, r_rd;

  dpr_port #(.AW(AW), .DW(DW)) u_lport (
    .clk(l_clk), .rst_n(rst_n), .cs_n(l_cs_n), .cs(l_cs), .we_n(l_we_n),
    .oe_n(l_oe_n), .pipe(l_pipe), .addr(l_addr), .din(l_din),
    .sel(l_sel), .wr_en(l_wr), .wr_addr(l_wa), .wr_data(l_wd),
    .rd_addr(l_ra), .rd_data(l_rd), .dout(l_dout), .drive(l_drive)
  );

  dpr_port #(.AW(AW), .DW(DW)) u_rport (
    .clk(r_clk), .rst_n(rst_n), .cs_n(r_cs_n), .cs(r_cs), .we_n(r_we_n),
    .oe_n(r_oe_n), .pipe(r_pipe), .addr(r_addr), .din(r_din),
    .sel(r_sel), .wr_en(r_wr), .wr_addr(r_wa), .wr_data(r_wd),
    .rd_addr(r_ra), .rd_data(r_rd), .dout(r_dout), .drive(r_drive)
  );

  dpr_store #(.AW(AW), .DW(DW)) u_store (
    .a_clk(l_clk), .a_we(l_wr), .a_waddr(l_wa), .a_wdata(l_wd),
    .a_raddr(l_ra), .a_rdata(l_rd),
    .b_clk(r_clk), .b_we(r_wr), .b_waddr(r_wa), .b_wdata(r_wd),
    .b_raddr(r_ra), .b_rdata(r_rd)
  );

endmodule

// File: rtl/dpr_ram_chk.sv
module dpr_ram_chk (
  input logic rst_n,
  input logic l_clk,
  input logic l_sel,
  input logic l_we_n,
  input logic l_oe_n,
  input logic l_pipe,
  input logic l_drive,
  input logic r_clk,
  input logic r_sel,
  input logic r_we_n,
  input logic r_oe_n,
  input logic r_pipe,
  input logic r_drive
);
  // R5: a deselected edge leaves the output off afterwards
  a_r5_l_deselect_off: assert property (@(posedge l_clk) disable iff (!rst_n)
    !l_sel |=> !l_drive);
  a_r5_r_deselect_off: assert property (@(posedge r_clk) disable iff (!rst_n)
    !r_sel |=> !r_drive);

  // R7: output enable high never lets the port drive
  a_r7_l_oe_gate: assert property (@(posedge l_clk) disable iff (!rst_n)
    l_oe_n |-> !l_drive);
  a_r7_r_oe_gate: assert property (@(posedge r_clk) disable iff (!rst_n)
    r_oe_n |-> !r_drive);

  // R3: flow-through drive comes from a selected read at the previous edge
  a_r3_l_flow_src: assert property (@(posedge l_clk) disable iff (!rst_n)
    (!l_pipe && l_drive) |-> ($past(l_sel) && $past(l_we_n)));

  // R6: pipelined drive needs two consecutive selected edges
  a_r6_l_wake: assert property (@(posedge l_clk) disable iff (!rst_n)
    (l_pipe && l_drive) |-> ($past(l_sel, 1) && $past(l_sel, 2) && $past(l_we_n, 2)));
  a_r6_r_wake: assert property (@(posedge r_clk) disable iff (!rst_n)
    (r_pipe && r_drive) |-> ($past(r_sel, 1) && $past(r_sel, 2) && $past(r_we_n, 2)));

  // R9: output after a write follows the previous controls
  a_r9_l_flow_write_off: assert property (@(posedge l_clk) disable iff (!rst_n)
    (!l_pipe && l_sel && !l_we_n) |=> !l_drive);
  a_r9_r_pipe_write_off: assert property (@(posedge r_clk) disable iff (!rst_n)
    (r_pipe && $past(r_sel && !r_we_n, 2)) |-> !r_drive);

endmodule

bind dpr_ram dpr_ram_chk u_chk (
  .rst_n(rst_n),
  .l_clk(l_clk), .l_sel(l_sel), .l_we_n(l_we_n), .l_oe_n(l_oe_n),
  .l_pipe(l_pipe), .l_drive(l_drive),
  .r_clk(r_clk), .r_sel(r_sel), .r_we_n(r_we_n), .r_oe_n(r_oe_n),
  .r_pipe(r_pipe), .r_drive(r_drive)
);

// File: tb/dpr_ram_test.sv
`timescale 1ns/1ps
module dpr_ram_test;
  localparam int AW = 10;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  // op codes for the stimulus task
  localparam int OP_IDLE = 0;  // active-low select high
  localparam int OP_RD   = 1;
  localparam int OP_WR   = 2;
  localparam int OP_OFFW = 3;  // active-high select low, write strobe low

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n;
  logic l_cs_n, l_cs, l_we_n, l_oe_n, l_pipe;
  logic r_cs_n, r_cs, r_we_n, r_oe_n, r_pipe;
  logic [AW-1:0] l_addr, r_addr;
  logic [DW-1:0] l_din, r_din, l_dout, r_dout;
  logic l_drive, r_drive;

  dpr_ram #(.AW(AW), .DW(DW)) uut (
    .rst_n(rst_n),
    .l_clk(clk), .l_cs_n(l_cs_n), .l_cs(l_cs), .l_we_n(l_we_n), .l_oe_n(l_oe_n),
    .l_pipe(l_pipe), .l_addr(l_addr), .l_din(l_din), .l_dout(l_dout), .l_drive(l_drive),
    .r_clk(clk), .r_cs_n(r_cs_n), .r_cs(r_cs), .r_we_n(r_we_n), .r_oe_n(r_oe_n),
    .r_pipe(r_pipe), .r_addr(r_addr), .r_din(r_din), .r_dout(r_dout), .r_drive(r_drive)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string tag = "R10";

  // reference model state
  logic [DW-1:0] mm [DEPTH];
  bit            prev_rd [2];
  int            prev_a  [2];
  logic [DW-1:0] pdat    [2];
  bit            pdrv    [2];
  bit            fdrv    [2];
  logic [DW-1:0] fdat    [2];

  task automatic check(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  function automatic bit exp_drv(input int p);
    bit pp = (p == 0) ? l_pipe : r_pipe;
    bit oe = (p == 0) ? l_oe_n : r_oe_n;
    return (pp ? pdrv[p] : fdrv[p]) && !oe;
  endfunction

  function automatic int exp_dat(input int p);
    bit pp = (p == 0) ? l_pipe : r_pipe;
    if (!exp_drv(p)) return 0;
    return pp ? int'(pdat[p]) : int'(fdat[p]);
  endfunction

  task automatic compare_all(input string req);
    check(req, "left drive", int'(l_drive), int'(exp_drv(0)));
    check(req, "left data", int'(l_dout), exp_dat(0));
    check(req, "right drive", int'(r_drive), int'(exp_drv(1)));
    check(req, "right data", int'(r_dout), exp_dat(1));
  endtask

  task automatic set_port(input int p, input int op, input int a, input int d);
    logic csn, cs, wen;
    csn = (op == OP_IDLE);
    cs  = (op != OP_OFFW);
    wen = !(op == OP_WR || op == OP_OFFW);
    if (p == 0) begin
      l_cs_n = csn; l_cs = cs; l_we_n = wen; l_addr = AW'(a); l_din = DW'(d);
    end else begin
      r_cs_n = csn; r_cs = cs; r_we_n = wen; r_addr = AW'(a); r_din = DW'(d);
    end
  endtask

  // One cycle: drive at negedge, model at posedge, compare at next negedge.
  task automatic step(input int lop, input int la, input int ld,
                      input int rop, input int ra, input int rd);
    int  ops [2];
    int  as  [2];
    int  ds  [2];
    ops[0] = lop; ops[1] = rop; as[0] = la; as[1] = ra; ds[0] = ld; ds[1] = rd;
    set_port(0, lop, la, ld);
    set_port(1, rop, ra, rd);
    @(posedge clk);
    for (int p = 0; p < 2; p++) begin
      bit s = (ops[p] == OP_RD) || (ops[p] == OP_WR);
      if (prev_rd[p]) pdat[p] = mm[prev_a[p]];
      pdrv[p] = prev_rd[p] && s;
    end
    if (ops[0] == OP_WR) mm[as[0]] = DW'(ds[0]);
    if (ops[1] == OP_WR) mm[as[1]] = DW'(ds[1]);   // right wins a collision
    for (int p = 0; p < 2; p++) begin
      bit rdop = (ops[p] == OP_RD);
      fdrv[p]    = rdop;
      fdat[p]    = mm[as[p]];
      prev_rd[p] = rdop;
      prev_a[p]  = as[p];
    end
    @(negedge clk);
    compare_all(tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    set_port(0, OP_IDLE, 0, 0);
    set_port(1, OP_IDLE, 0, 0);
    l_oe_n = 1'b0; r_oe_n = 1'b0;
    for (int p = 0; p < 2; p++) begin
      prev_rd[p] = 0; prev_a[p] = 0; pdat[p] = '0; pdrv[p] = 0; fdrv[p] = 0; fdat[p] = '0;
    end
    repeat (3) @(negedge clk);
    check("R12", "left drive in reset", int'(l_drive), 0);
    check("R12", "right data in reset", int'(r_dout), 0);
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R12");
  endtask

  task automatic phase(input bit lp, input bit rp);
    l_pipe = lp; r_pipe = rp;
    do_reset();
    // R2 R10: both ports fill the array, then read across
    tag = "R2";
    for (int i = 0; i < DEPTH / 2; i++)
      step(OP_WR, i, (i * 7 + 3 + lp) & 8'hff, OP_WR, i + DEPTH / 2, (i * 13 + 1 + rp) & 8'hff);
    tag = "R10";
    for (int i = 0; i < 8; i++)
      step(OP_RD, DEPTH / 2 + i, 0, OP_RD, i, 0);
    step(OP_RD, DEPTH - 1, 0, OP_RD, 0, 0);
    // R3 R4: back-to-back reads of distinct words
    tag = lp ? "R4" : "R3";
    for (int i = 0; i < 6; i++) step(OP_RD, 20 + i, 0, OP_IDLE, 0, 0);
    tag = rp ? "R4" : "R3";
    for (int i = 0; i < 6; i++) step(OP_IDLE, 0, 0, OP_RD, 40 + i, 0);
    // R9: read, write, read on each port
    tag = "R9";
    step(OP_RD, 30, 0, OP_RD, 31, 0);
    step(OP_WR, 30, 8'h5a, OP_WR, 31, 8'ha5);
    step(OP_RD, 30, 0, OP_RD, 31, 0);
    step(OP_RD, 31, 0, OP_RD, 30, 0);
    step(OP_IDLE, 0, 0, OP_IDLE, 0, 0);
    // R1: wrong-polarity select with write strobe low must not write
    tag = "R1";
    step(OP_OFFW, 50, 8'hee, OP_OFFW, 51, 8'hdd);
    step(OP_RD, 50, 0, OP_RD, 51, 0);
    step(OP_RD, 50, 0, OP_RD, 51, 0);
    check("R1", "left word 50 unchanged", int'(mm[50]), (50 * 7 + 3 + lp) & 8'hff);
    // R5: deselect in the middle of a read stream
    tag = "R5";
    step(OP_RD, 60, 0, OP_RD, 61, 0);
    step(OP_IDLE, 60, 0, OP_OFFW, 61, 0);
    step(OP_RD, 62, 0, OP_RD, 63, 0);
    // R6: pipelined wake-up needs two selected edges
    tag = "R6";
    step(OP_IDLE, 0, 0, OP_IDLE, 0, 0);
    step(OP_RD, 70, 0, OP_RD, 71, 0);
    if (lp) check("R6", "left off after one selected edge", int'(l_drive), 0);
    if (rp) check("R6", "right off after one selected edge", int'(r_drive), 0);
    step(OP_RD, 72, 0, OP_RD, 73, 0);
    check("R6", "left on after two selected edges", int'(l_drive), 1);
    check("R6", "right on after two selected edges", int'(r_drive), 1);
    // R7 R8: output enable between edges
    tag = "R7";
    step(OP_RD, 74, 0, OP_RD, 75, 0);
    l_oe_n = 1'b1; r_oe_n = 1'b1;
    #0.5;
    compare_all("R8");
    check("R7", "left drive with oe high", int'(l_drive), 0);
    l_oe_n = 1'b0; r_oe_n = 1'b0;
    #0.5;
    compare_all("R7");
    // R11: same-word collision
    tag = "R11";
    step(OP_WR, 80, 8'h11, OP_WR, 80, 8'h22);
    step(OP_RD, 80, 0, OP_RD, 80, 0);
    step(OP_RD, 80, 0, OP_RD, 80, 0);
    step(OP_RD, 80, 0, OP_RD, 80, 0);
    check("R11", "model word after collision", int'(mm[80]), 8'h22);
    // R10: random concurrent traffic on a small address set
    tag = "R10";
    for (int i = 0; i < 400; i++) begin
      int lo = $urandom_range(0, 3);
      int ro = $urandom_range(0, 3);
      l_oe_n = ($urandom_range(0, 7) == 0);
      r_oe_n = ($urandom_range(0, 7) == 0);
      step(lo, $urandom_range(0, 15), $urandom_range(0, 255),
           ro, $urandom_range(0, 15), $urandom_range(0, 255));
    end
    l_oe_n = 1'b0; r_oe_n = 1'b0;
  endtask

  initial begin
    l_pipe = 1'b0; r_pipe = 1'b1;
    rst_n = 1'b0;
    set_port(0, OP_IDLE, 0, 0);
    set_port(1, OP_IDLE, 0, 0);
    l_oe_n = 1'b0; r_oe_n = 1'b0;
    @(negedge clk);
    phase(1'b0, 1'b1);
    phase(1'b1, 1'b0);
    phase(1'b1, 1'b1);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule